// File: doc/BRIEF.md
# Layer Pixel Format Converter

This block is the per-layer conversion stage that sits between a frame-buffer fetch engine and a layer blender. It accepts 32-bit words holding packed pixels in one of eight input encodings, cuts each word into its pixels (a word may hold one, two or four pixels, and 24-bit pixels straddle word boundaries), and expands every pixel to a 32-bit direct ARGB value with alpha in bits 31:24, red in 23:16, green in 15:8 and blue in 7:0.

Indexed encodings look their color up in an internal 256-entry RGB table that is loaded through a simple write strobe. After decoding, an optional transparent-color match forces the whole pixel to zero, and the alpha channel can be passed through, replaced by a constant, or scaled by a constant. Words enter and pixels leave through valid/ready handshakes. The format, key and alpha settings are meant to change only between streams, when no pixel is in flight.

Top module: `pfc_layer_conv`

## Requirements
- R1: While reset is high and in the first cycle after it, out_valid is 0, in_ready is 1 and lut_err is 0.
- R2: With cfg_mode 0 (32-bit ARGB), each word yields one pixel equal to the word.
- R3: With cfg_mode 2 (RGB 5-6-5), 3 (1-bit alpha with 5-5-5 RGB) or 4 (4-4-4-4 ARGB), each word yields two pixels, bits 15:0 first. Fields lie from the top bit down in the order alpha, red, green, blue. Each field widens to 8 bits by appending its own top bits. A 1-bit alpha of 1 gives 0xFF and of 0 gives 0x00, and RGB 5-6-5 gives alpha 0xFF.
- R4: With cfg_mode 1 (24-bit RGB), three words yield four pixels. Pixel k is taken from bits 24k+23:24k of the 96-bit little-endian concatenation of the words. Blue is its lowest byte, and alpha is 0xFF.
- R5: With cfg_mode 5 (8-bit index), each word yields four pixels, lowest byte first. The pixel's RGB is the table entry at that byte, and its alpha is 0xFF.
- R6: With cfg_mode 7 (8-bit alpha plus 8-bit index), each 16-bit pixel carries alpha in bits 15:8 and the table index in bits 7:0.
- R7: With cfg_mode 6 (4-bit alpha plus 4-bit index), each byte yields one pixel. Alpha is bits 7:4 replicated to 8 bits. The RGB is the table entry at the address formed by repeating the index nibble twice.
- R8: When cfg_key_en is 1 and a decoded pixel's RGB equals cfg_key_rgb, the output pixel is 0x00000000. When cfg_key_en is 0, the key has no effect.
- R9: cfg_alpha_mode 0 or 3 keeps the decoded alpha. Mode 1 replaces it with cfg_const_alpha. Mode 2 replaces it with (a*cfg_const_alpha+127)/255, rounded down.
- R10: While out_valid is 1 and out_ready is 0, out_valid and out_pix hold. Pixels leave in input order, with none lost or repeated.
- R11: A lut_wr pulse while the block holds no data writes lut_data to entry lut_addr. A pulse while data is held leaves the table unchanged and sets lut_err, which stays 1 until reset.
- R12: When the block is empty and out_ready is 1, the first pixel of an accepted word is valid at the output one clock edge after the edge that accepts the word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_word | input | 32 | Packed pixel word |
| in_valid | input | 1 | in_word is valid |
| in_ready | output | 1 | Block accepts in_word this cycle |
| out_pix | output | 32 | Converted ARGB pixel |
| out_valid | output | 1 | out_pix is valid |
| out_ready | input | 1 | Consumer takes out_pix this cycle |
| cfg_mode | input | 3 | Input encoding select |
| cfg_key_en | input | 1 | Enable transparent-color match |
| cfg_key_rgb | input | 24 | Transparent color, RGB |
| cfg_alpha_mode | input | 2 | Alpha handling select |
| cfg_const_alpha | input | 8 | Constant alpha value |
| lut_wr | input | 1 | Table write strobe |
| lut_addr | input | 8 | Table write address |
| lut_data | input | 24 | Table write RGB value |
| lut_err | output | 1 | Sticky flag for a write refused while busy |

## Verification
A word taken at a clock edge produces its first pixel one edge later. Later pixels of the same word follow one per edge while out_ready stays high. The bench therefore pushes the expected pixels of each group into a queue before it drives the words, and compares a pixel only at a falling edge where out_valid and out_ready are both high. A refused table write raises lut_err at the edge that samples the strobe, so the bench checks the flag at the falling edge that ends the strobe. The latency check samples out_valid exactly one falling edge after the acceptance edge.

// File: rtl/pfc_pkg.sv
package pfc_pkg;

    localparam int WORD_W = 32;
    localparam int BUF_W  = 2 * WORD_W;
    localparam int CNT_W  = $clog2(BUF_W) + 1;

    typedef enum logic [2:0] {
        FMT_ARGB32  = 3'd0,
        FMT_RGB24   = 3'd1,
        FMT_RGB16   = 3'd2,
        FMT_A1RGB15 = 3'd3,
        FMT_ARGB16  = 3'd4,
        FMT_IDX8    = 3'd5,
        FMT_AI44    = 3'd6,
        FMT_AI88    = 3'd7
    } pfc_fmt_e;

    typedef enum logic [1:0] {
        AM_KEEP  = 2'd0,
        AM_CONST = 2'd1,
        AM_SCALE = 2'd2,
        AM_KEEPB = 2'd3
    } pfc_amode_e;

    typedef struct packed {
        logic [7:0] a;
        logic [7:0] r;
        logic [7:0] g;
        logic [7:0] b;
        logic       use_lut;
        logic [7:0] idx;
    } pfc_dec_t;

    function automatic logic [CNT_W-1:0] pix_bits(input pfc_fmt_e f);
        case (f)
            FMT_ARGB32:           return CNT_W'(32);
            FMT_RGB24:            return CNT_W'(24);
            FMT_IDX8, FMT_AI44:   return CNT_W'(8);
            default:              return CNT_W'(16);
        endcase
    endfunction

    function automatic logic [7:0] wid5(input logic [4:0] v);
        return {v, v[4:2]};
    endfunction

    function automatic logic [7:0] wid6(input logic [5:0] v);
        return {v, v[5:4]};
    endfunction

    function automatic logic [7:0] wid4(input logic [3:0] v);
        return {v, v};
    endfunction

    function automatic pfc_dec_t decode(input pfc_fmt_e f, input logic [WORD_W-1:0] w);
        pfc_dec_t d;
        d = '{a: 8'hFF, r: 8'h00, g: 8'h00, b: 8'h00, use_lut: 1'b0, idx: 8'h00};
        case (f)
            FMT_ARGB32: begin
                d.a = w[31:24]; d.r = w[23:16]; d.g = w[15:8]; d.b = w[7:0];
            end
            FMT_RGB24: begin
                d.r = w[23:16]; d.g = w[15:8]; d.b = w[7:0];
            end
            FMT_RGB16: begin
                d.r = wid5(w[15:11]); d.g = wid6(w[10:5]); d.b = wid5(w[4:0]);
            end
            FMT_A1RGB15: begin
                d.a = {8{w[15]}};
                d.r = wid5(w[14:10]); d.g = wid5(w[9:5]); d.b = wid5(w[4:0]);
            end
            FMT_ARGB16: begin
                d.a = wid4(w[15:12]); d.r = wid4(w[11:8]);
                d.g = wid4(w[7:4]);   d.b = wid4(w[3:0]);
            end
            FMT_IDX8: begin
                d.use_lut = 1'b1; d.idx = w[7:0];
            end
            FMT_AI44: begin
                d.use_lut = 1'b1; d.a = wid4(w[7:4]); d.idx = wid4(w[3:0]);
            end
            default: begin
                d.use_lut = 1'b1; d.a = w[15:8]; d.idx = w[7:0];
            end
        endcase
        return d;
    endfunction

endpackage

// File: rtl/pfc_unpack.sv
module pfc_unpack
    import pfc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  pfc_fmt_e          fmt,
    input  logic [WORD_W-1:0] in_word,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic              take,
    output logic [WORD_W-1:0] raw,
    output logic              raw_valid,
    output logic              holding
);
    logic [BUF_W-1:0] buf_q, buf_d;
    logic [CNT_W-1:0] cnt_q, cnt_d, bpp;
    logic             pop, push;

    assign bpp       = pix_bits(fmt);
    assign raw_valid = cnt_q >= bpp;
    assign raw       = buf_q[WORD_W-1:0];
    assign in_ready  = cnt_q <= CNT_W'(WORD_W);
    assign holding   = cnt_q != '0;
    assign pop       = take && raw_valid;
    assign push      = in_valid && in_ready;

    always_comb begin
        buf_d = buf_q;
        cnt_d = cnt_q;
        if (pop) begin
            buf_d = buf_q >> bpp;
            cnt_d = cnt_q - bpp;
        end
        if (push) begin
            buf_d = buf_d | ({{(BUF_W-WORD_W){1'b0}}, in_word} << cnt_d);
            cnt_d = cnt_d + CNT_W'(WORD_W);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            buf_q <= '0;
            cnt_q <= '0;
        end else begin
            buf_q <= buf_d;
            cnt_q <= cnt_d;
        end
    end

    a_r10_fill_bound: assert property (@(posedge clk) disable iff (rst)
        push |=> cnt_q >= CNT_W'(WORD_W));

endmodule

// File: rtl/pfc_lut.sv
module pfc_lut #(
    parameter int AW = 8,
    parameter int DW = 24
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/pfc_finish.sv
module pfc_finish
    import pfc_pkg::*;
(
    input  pfc_dec_t    dec,
    input  logic [23:0] lut_rgb,
    input  pfc_amode_e  amode,
    input  logic [7:0]  kconst,
    input  logic        key_en,
    input  logic [23:0] key_rgb,
    output logic [31:0] pix,
    output logic        key_hit
);
    logic [23:0] rgb;
    logic [15:0] prod;
    logic [16:0] rnd;
    logic [7:0]  scaled, a_out;

    assign rgb    = dec.use_lut ? lut_rgb : {dec.r, dec.g, dec.b};
    assign prod   = dec.a * kconst;
    assign rnd    = {1'b0, prod} + 17'd128;
    assign scaled = 8'((rnd + (rnd >> 8)) >> 8);

    always_comb begin
        case (amode)
            AM_CONST: a_out = kconst;
            AM_SCALE: a_out = scaled;
            default:  a_out = dec.a;
        endcase
    end

    assign key_hit = key_en && (rgb == key_rgb);
    assign pix     = key_hit ? 32'h0 : {a_out, rgb};

endmodule

// File: rtl/pfc_layer_conv.sv
module pfc_layer_conv
    import pfc_pkg::*;
#(
    parameter int LUT_AW = 8
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [31:0] in_word,
    input  logic        in_valid,
    output logic        in_ready,
    output logic [31:0] out_pix,
    output logic        out_valid,
    input  logic        out_ready,
    input  logic [2:0]  cfg_mode,
    input  logic        cfg_key_en,
    input  logic [23:0] cfg_key_rgb,
    input  logic [1:0]  cfg_alpha_mode,
    input  logic [7:0]  cfg_const_alpha,
    input  logic        lut_wr,
    input  logic [7:0]  lut_addr,
    input  logic [23:0] lut_data,
    output logic        lut_err
);
    localparam int RGB_W = 24;

    pfc_fmt_e    fmt;
    logic        adv, raw_valid, holding, busy, key_hit;
    logic [31:0] raw, conv;
    logic [23:0] lut_rgb;
    pfc_dec_t    dec;
    logic        ov_q, err_q;
    logic [31:0] pix_q;

    assign fmt  = pfc_fmt_e'(cfg_mode);
    assign adv  = !ov_q || out_ready;
    assign busy = holding || ov_q;

    pfc_unpack u_unpack (
        .clk(clk), .rst(rst), .fmt(fmt),
        .in_word(in_word), .in_valid(in_valid), .in_ready(in_ready),
        .take(adv), .raw(raw), .raw_valid(raw_valid), .holding(holding)
    );

    assign dec = decode(fmt, raw);

    pfc_lut #(.AW(LUT_AW), .DW(RGB_W)) u_lut (
        .clk(clk), .we(lut_wr && !busy),
        .waddr(lut_addr[LUT_AW-1:0]), .wdata(lut_data),
        .raddr(dec.idx[LUT_AW-1:0]), .rdata(lut_rgb)
    );

    pfc_finish u_finish (
        .dec(dec), .lut_rgb(lut_rgb),
        .amode(pfc_amode_e'(cfg_alpha_mode)), .kconst(cfg_const_alpha),
        .key_en(cfg_key_en), .key_rgb(cfg_key_rgb),
        .pix(conv), .key_hit(key_hit)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ov_q  <= 1'b0;
            pix_q <= '0;
            err_q <= 1'b0;
        end else begin
            if (adv) begin
                ov_q <= raw_valid;
                if (raw_valid) pix_q <= conv;
            end
            if (lut_wr && busy) err_q <= 1'b1;
        end
    end

    assign out_valid = ov_q;
    assign out_pix   = pix_q;
    assign lut_err   = err_q;

    a_r10_hold: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |=> out_valid && $stable(out_pix));

    a_r11_sticky: assert property (@(posedge clk) disable iff (rst)
        lut_err |=> lut_err);

    a_r11_busy_write: assert property (@(posedge clk) disable iff (rst)
        lut_wr && busy |=> lut_err);

    a_r12_latency: assert property (@(posedge clk) disable iff (rst)
        in_valid && in_ready && !busy |=> ##1 out_valid);

    a_r9_const_alpha: assert property (@(posedge clk) disable iff (rst)
        adv && raw_valid && !key_hit && cfg_alpha_mode == 2'd1
        |=> out_pix[31:24] == $past(cfg_const_alpha));

    a_r8_key_zero: assert property (@(posedge clk) disable iff (rst)
        adv && raw_valid && key_hit |=> out_pix == 32'h0);

endmodule

// File: tb/pfc_layer_conv_test.sv
module pfc_layer_conv_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] in_word = '0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [31:0] out_pix;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [2:0]  cfg_mode = '0;
    logic        cfg_key_en = 1'b0;
    logic [23:0] cfg_key_rgb = '0;
    logic [1:0]  cfg_alpha_mode = '0;
    logic [7:0]  cfg_const_alpha = '0;
    logic        lut_wr = 1'b0;
    logic [7:0]  lut_addr = '0;
    logic [23:0] lut_data = '0;
    logic        lut_err;

    pfc_layer_conv uut (.*);

    always #10 clk = ~clk;

    int n_chk = 0, n_err = 0, cyc = 0;
    logic [31:0] expq[$];
    string       expr[$];
    logic [23:0] lut_m [256];
    bit          force_ready = 0, force_stall = 0, prev_stall = 0;
    logic [31:0] prev_pix;
    string       cur_req = "R2";

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    function automatic int bits_of(input int m);
        case (m)
            0: return 32;
            1: return 24;
            5, 6: return 8;
            default: return 16;
        endcase
    endfunction

    function automatic logic [7:0] w5(input logic [4:0] v); return {v, v[4:2]}; endfunction
    function automatic logic [7:0] w4(input logic [3:0] v); return {v, v}; endfunction

    function automatic logic [31:0] exp_pix(input int m, input logic [31:0] r);
        logic [7:0] a; logic [23:0] c; int t;
        a = 8'hFF;
        case (m)
            0: begin a = r[31:24]; c = r[23:0]; end
            1: c = r[23:0];
            2: c = {w5(r[15:11]), r[10:5], r[10:9], w5(r[4:0])};
            3: begin a = r[15] ? 8'hFF : 8'h00; c = {w5(r[14:10]), w5(r[9:5]), w5(r[4:0])}; end
            4: begin a = w4(r[15:12]); c = {w4(r[11:8]), w4(r[7:4]), w4(r[3:0])}; end
            5: c = lut_m[r[7:0]];
            6: begin a = w4(r[7:4]); c = lut_m[{r[3:0], r[3:0]}]; end
            default: begin a = r[15:8]; c = lut_m[r[7:0]]; end
        endcase
        if (cfg_alpha_mode == 2'd1) a = cfg_const_alpha;
        else if (cfg_alpha_mode == 2'd2) begin
            t = (int'(a) * int'(cfg_const_alpha) + 127) / 255;
            a = 8'(t);
        end
        if (cfg_key_en && c == cfg_key_rgb) return 32'h0;
        return {a, c};
    endfunction

    // output side: decide ready, then score the pixel the next edge takes
    always @(negedge clk) begin
        if (!rst) begin
            if (prev_stall)
                chk(out_valid && out_pix == prev_pix, "R10", out_pix, prev_pix);
            out_ready = force_stall ? 1'b0 : (force_ready ? 1'b1 : ($urandom % 4 != 0));
            if (out_valid && out_ready) begin
                if (expq.size() == 0) chk(0, "R10", out_pix, 32'hx);
                else begin
                    automatic logic [31:0] e = expq.pop_front();
                    automatic string rq = expr.pop_front();
                    chk(out_pix === e, rq, out_pix, e);
                end
            end
            prev_stall = out_valid && !out_ready;
            prev_pix   = out_pix;
        end
    end

    task automatic report_end();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_err++; n_chk++;
            $display("FAIL watchdog actual=%0d expected=<150000", cyc);
            report_end();
        end
    end

    task automatic send_word(input logic [31:0] w);
        in_word = w; in_valid = 1'b1;
        while (!in_ready) @(negedge clk);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic send_group(input logic [95:0] bits, input int nwords);
        int bpp = bits_of(int'(cfg_mode));
        int n = nwords * 32 / bpp;
        for (int i = 0; i < n; i++) begin
            expq.push_back(exp_pix(int'(cfg_mode), 32'(bits >> (i * bpp))));
            expr.push_back(cur_req);
        end
        for (int i = 0; i < nwords; i++) send_word(bits[i*32 +: 32]);
    endtask

    task automatic drain();
        while (expq.size() != 0 || out_valid) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    task automatic cfg(input int m, input bit ke, input logic [23:0] k, input int am, input logic [7:0] ka);
        drain();
        cfg_mode = 3'(m); cfg_key_en = ke; cfg_key_rgb = k;
        cfg_alpha_mode = 2'(am); cfg_const_alpha = ka;
    endtask

    task automatic lut_write(input logic [7:0] a, input logic [23:0] d);
        lut_wr = 1'b1; lut_addr = a; lut_data = d;
        @(negedge clk);
        lut_wr = 1'b0;
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        chk(out_valid == 0, "R1", {31'b0, out_valid}, 0);
        chk(in_ready == 1, "R1", {31'b0, in_ready}, 1);
        chk(lut_err == 0, "R1", {31'b0, lut_err}, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(out_valid == 0 && in_ready == 1 && lut_err == 0, "R1",
            {29'b0, out_valid, in_ready, lut_err}, 32'b010);

        for (int i = 0; i < 256; i++) begin
            lut_m[i] = 24'($urandom);
            lut_write(8'(i), lut_m[i]);
        end
        chk(lut_err == 0, "R11", {31'b0, lut_err}, 0);

        // R12 latency with ready held high
        force_ready = 1;
        cfg(0, 0, 0, 0, 0);
        cur_req = "R12";
        send_group({64'b0, 32'hA1B2C3D4}, 1);
        @(negedge clk);
        chk(out_valid == 1, "R12", {31'b0, out_valid}, 1);
        force_ready = 0;

        // R2 passthrough, R8 key hit and key disabled
        cur_req = "R2";
        send_group({64'b0, 32'h12AABBCC}, 1);
        cfg(0, 1, 24'hAABBCC, 0, 0);
        cur_req = "R8";
        send_group({64'b0, 32'h12AABBCC}, 1);
        send_group({64'b0, 32'h12AABBCD}, 1);
        cfg(0, 0, 24'hAABBCC, 0, 0);
        send_group({64'b0, 32'h12AABBCC}, 1);

        // R4 straddling 24-bit pixels
        cfg(1, 0, 0, 0, 0);
        cur_req = "R4";
        send_group({32'h89ABCDEF, 32'h01234567, 32'h76543210}, 3);

        // R3 sixteen-bit encodings
        cfg(2, 0, 0, 0, 0); cur_req = "R3";
        send_group({64'b0, 32'hF81F07E0}, 1);
        cfg(3, 0, 0, 0, 0);
        send_group({64'b0, 32'h7FFF8001}, 1);
        cfg(4, 0, 0, 0, 0);
        send_group({64'b0, 32'h1234F0A5}, 1);

        // R5 / R6 / R7 indexed forms
        cfg(5, 0, 0, 0, 0); cur_req = "R5";
        send_group({64'b0, 32'hFF00017F}, 1);
        cfg(7, 0, 0, 0, 0); cur_req = "R6";
        send_group({64'b0, 32'h40FFC003}, 1);
        cfg(6, 0, 0, 0, 0); cur_req = "R7";
        send_group({64'b0, 32'h0F31A2F5}, 1);

        // R9 alpha modes
        cfg(0, 0, 0, 2, 8'h80); cur_req = "R9";
        send_group({64'b0, 32'h80112233}, 1);
        send_group({64'b0, 32'hFF112233}, 1);
        send_group({64'b0, 32'h00112233}, 1);
        cfg(0, 0, 0, 1, 8'h5A);
        send_group({64'b0, 32'hC0445566}, 1);
        cfg(0, 0, 0, 3, 8'h5A);
        send_group({64'b0, 32'hC0445566}, 1);

        // R11 write while busy is refused, write while idle is taken
        cfg(5, 0, 0, 0, 0);
        force_stall = 1;
        cur_req = "R11";
        send_group({64'b0, 32'h05050505}, 1);
        lut_write(8'h05, ~lut_m[5]);
        chk(lut_err == 1, "R11", {31'b0, lut_err}, 1);
        force_stall = 0;
        drain();
        chk(lut_err == 1, "R11", {31'b0, lut_err}, 1);
        send_group({64'b0, 32'h05050505}, 1);
        drain();
        lut_m[6] = ~lut_m[6];
        lut_write(8'h06, lut_m[6]);
        send_group({64'b0, 32'h06060606}, 1);

        // random mix
        cur_req = "R10";
        for (int it = 0; it < 250; it++) begin
            automatic int m = $urandom % 8;
            automatic int ng = 1 + $urandom % 3;
            automatic bit ke = ($urandom % 4 == 0);
            automatic logic [23:0] k = lut_m[$urandom % 256];
            cfg(m, ke, k, $urandom % 4, 8'($urandom));
            for (int g = 0; g < ng; g++) begin
                automatic logic [95:0] b = {$urandom, $urandom, $urandom};
                if ($urandom % 3 == 0) b[23:0] = k;
                send_group(b, m == 1 ? 3 : 1);
            end
        end
        drain();
        report_end();
    end

endmodule